// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel placed next to a timer/counter. It keeps an 8-bit compare value. On every timer tick it checks that value against the running count. When the two are equal it raises a sticky interrupt-request flag, gives a one-cycle match pulse, and sets, clears or toggles a waveform output, as a 2-bit output-action field selects. The counter is a separate block that feeds the count, its top and bottom indications and the tick enable into this channel.

In the two PWM waveform modes, software writes land in a holding register. The active compare value copies that holding register only at the counting boundary that belongs to the mode. Because of this, a period is never cut short or made uneven by a write in the middle of the period. In the two non-PWM modes, writes reach the active value directly. Software can also make the output action happen through a force strobe, which leaves the flag alone. A software write to the counter masks the compare on the next timer tick, so that the counter and the compare value can be set equal without a spurious interrupt.

Top module: `ocu_channel`

## Requirements
- R1: With `wave_mode` 2 (fast PWM, reload at bottom) or 3 (phase-correct PWM, reload at top), a compare write changes only `cmp_shadow`. `cmp_active` copies `cmp_shadow` only on a cycle with `tick_en` high and the mode's boundary input (`at_bottom` for 2, `at_top` for 3) high, and stays unchanged on every other cycle.
- R2: With `wave_mode` 0 (normal) or 1 (clear on compare), a compare write updates both `cmp_active` and `cmp_shadow` on the next clock edge.
- R3: On a clock edge where `tick_en` is high, `count_val` equals `cmp_active` and no block is pending, `cmp_flag` becomes 1 and `match_pulse` is 1 for exactly that following cycle.
- R4: On a match, `pin_mode` 1 toggles `wave_out`, 2 clears it and 3 sets it.
- R5: With `pin_mode` 0, `wave_out` keeps its value across matches and forces.
- R6: In `wave_mode` 0 or 1, a `cpu_force` pulse applies the `pin_mode` action to `wave_out` at the next edge, with no change to `cmp_flag` and no `match_pulse`. A force and a real match on the same edge toggle the output only once.
- R7: In `wave_mode` 2 or 3, `cpu_force` has no effect on `wave_out`.
- R8: A `cpu_cnt_we` pulse suppresses any match on the next edge that has `tick_en` high, however many idle cycles pass in between. The next tick after that one compares normally again.
- R9: `cpu_flag_clr` clears `cmp_flag`. If a clear and a new match happen on the same edge, the flag stays set.
- R10: After reset `cmp_flag`, `wave_out`, `match_pulse`, `cmp_active` and `cmp_shadow` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer tick enable; the compare is evaluated only on these cycles |
| count_val | input | 8 | Current counter value |
| at_top | input | 1 | Counter is at the top of its sequence |
| at_bottom | input | 1 | Counter is at the bottom of its sequence |
| wave_mode | input | 2 | 0 normal, 1 clear on compare, 2 fast PWM, 3 phase-correct PWM |
| pin_mode | input | 2 | 0 disconnected, 1 toggle, 2 clear, 3 set |
| cpu_cmp_we | input | 1 | Compare value write strobe |
| cpu_cmp_wdata | input | 8 | Compare value write data |
| cpu_cnt_we | input | 1 | Indicates a software write to the counter |
| cpu_force | input | 1 | Force-compare strobe |
| cpu_flag_clr | input | 1 | Write-one-to-clear of the match flag |
| cmp_flag | output | 1 | Sticky match flag, used as interrupt request |
| match_pulse | output | 1 | One-cycle pulse after a real match |
| wave_out | output | 1 | Waveform output level |
| cmp_active | output | 8 | Compare value currently in use |
| cmp_shadow | output | 8 | Holding register that takes the writes |

## Verification
The assertions assume that `wave_mode` and `pin_mode` are held steady from one edge to the next around the events they judge, and that `cpu_flag_clr` is never raised on a tick cycle whose result they predict. The directed tasks change modes only on cycles with no tick and no strobe. They also raise clear and tick together only in the one scenario built to show that the match wins. A copy of the pending-block state is kept in the checker from the inputs alone, so the masking rule is judged without looking at the design's own block flag.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

    typedef enum logic [1:0] {
        WM_NORMAL   = 2'd0,
        WM_CTC      = 2'd1,
        WM_PWM_FAST = 2'd2,
        WM_PWM_PC   = 2'd3
    } wave_mode_e;

    typedef enum logic [1:0] {
        PA_HOLD   = 2'd0,
        PA_TOGGLE = 2'd1,
        PA_CLEAR  = 2'd2,
        PA_SET    = 2'd3
    } pin_act_e;

    function automatic logic is_pwm(input logic [1:0] m);
        return (m == WM_PWM_FAST) || (m == WM_PWM_PC);
    endfunction

    function automatic logic apply_act(input logic [1:0] act, input logic cur);
        logic r;
        case (act)
            PA_TOGGLE: r = ~cur;
            PA_CLEAR:  r = 1'b0;
            PA_SET:    r = 1'b1;
            default:   r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ocu_cmp_store.sv
module ocu_cmp_store
    import ocu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         at_top,
    input  logic         at_bottom,
    input  logic [1:0]   wave_mode,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] active,
    output logic [W-1:0] shadow
);

    typedef struct packed {
        logic [W-1:0] act;
        logic [W-1:0] shd;
    } store_t;

    store_t st_d, st_q;
    logic   reload;

    always_comb begin
        st_d   = st_q;
        reload = 1'b0;
        if (wave_mode == WM_PWM_FAST) begin
            reload = tick_en && at_bottom;
        end else if (wave_mode == WM_PWM_PC) begin
            reload = tick_en && at_top;
        end
        if (is_pwm(wave_mode)) begin
            if (reload) begin
                st_d.act = st_q.shd;
            end
            if (wr_en) begin
                st_d.shd = wr_data;
            end
        end else if (wr_en) begin
            st_d.act = wr_data;
            st_d.shd = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.act;
    assign shadow = st_q.shd;

endmodule

// File: rtl/ocu_match_gate.sv
module ocu_match_gate #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic [W-1:0] count_val,
    input  logic [W-1:0] cmp_val,
    input  logic         cnt_wr,
    output logic         hit
);

    typedef struct packed {
        logic blk;
    } gate_t;

    gate_t g_d, g_q;
    logic  equal;

    always_comb begin
        g_d   = g_q;
        equal = (count_val == cmp_val);
        hit   = tick_en && equal && !g_q.blk;
        if (cnt_wr) begin
            g_d.blk = 1'b1;
        end else if (tick_en) begin
            g_d.blk = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

endmodule

// File: rtl/ocu_pin_flag.sv
module ocu_pin_flag
    import ocu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic       force_ok,
    input  logic [1:0] pin_mode,
    input  logic       flag_clr,
    output logic       flag,
    output logic       pin,
    output logic       pulse
);

    typedef struct packed {
        logic flag;
        logic pin;
        logic pulse;
    } pf_t;

    pf_t pf_d, pf_q;

    always_comb begin
        pf_d       = pf_q;
        pf_d.pulse = hit;
        if (hit || force_ok) begin
            pf_d.pin = apply_act(pin_mode, pf_q.pin);
        end
        if (hit) begin
            pf_d.flag = 1'b1;
        end else if (flag_clr) begin
            pf_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pf_q <= '0;
        end else begin
            pf_q <= pf_d;
        end
    end

    assign flag  = pf_q.flag;
    assign pin   = pf_q.pin;
    assign pulse = pf_q.pulse;

endmodule

// File: rtl/ocu_channel.sv
module ocu_channel
    import ocu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic [W-1:0] count_val,
    input  logic         at_top,
    input  logic         at_bottom,
    input  logic [1:0]   wave_mode,
    input  logic [1:0]   pin_mode,
    input  logic         cpu_cmp_we,
    input  logic [W-1:0] cpu_cmp_wdata,
    input  logic         cpu_cnt_we,
    input  logic         cpu_force,
    input  logic         cpu_flag_clr,
    output logic         cmp_flag,
    output logic         match_pulse,
    output logic         wave_out,
    output logic [W-1:0] cmp_active,
    output logic [W-1:0] cmp_shadow
);

    logic hit;
    logic force_ok;

    assign force_ok = cpu_force && !is_pwm(wave_mode);

    ocu_cmp_store #(.W(W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .at_top    (at_top),
        .at_bottom (at_bottom),
        .wave_mode (wave_mode),
        .wr_en     (cpu_cmp_we),
        .wr_data   (cpu_cmp_wdata),
        .active    (cmp_active),
        .shadow    (cmp_shadow)
    );

    ocu_match_gate #(.W(W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .count_val (count_val),
        .cmp_val   (cmp_active),
        .cnt_wr    (cpu_cnt_we),
        .hit       (hit)
    );

    ocu_pin_flag u_pf (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .force_ok (force_ok),
        .pin_mode (pin_mode),
        .flag_clr (cpu_flag_clr),
        .flag     (cmp_flag),
        .pin      (wave_out),
        .pulse    (match_pulse)
    );

endmodule

// File: rtl/ocu_channel_chk.sv
module ocu_channel_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick_en,
    input logic [W-1:0] count_val,
    input logic         at_top,
    input logic         at_bottom,
    input logic [1:0]   wave_mode,
    input logic [1:0]   pin_mode,
    input logic         cpu_cmp_we,
    input logic [W-1:0] cpu_cmp_wdata,
    input logic         cpu_cnt_we,
    input logic         cpu_force,
    input logic         cpu_flag_clr,
    input logic         cmp_flag,
    input logic         match_pulse,
    input logic         wave_out,
    input logic [W-1:0] cmp_active,
    input logic [W-1:0] cmp_shadow
);

    logic pend_q;
    logic bound;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (cpu_cnt_we) begin
            pend_q <= 1'b1;
        end else if (tick_en) begin
            pend_q <= 1'b0;
        end
    end

    assign bound = tick_en && ((wave_mode == 2'd2) ? at_bottom : at_top);

    a_r1_pwm_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_mode[1] && !bound) |=> $stable(cmp_active));

    a_r1_pwm_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_mode[1] && bound) |=> (cmp_active == $past(cmp_shadow)));

    a_r2_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!wave_mode[1] && cpu_cmp_we) |=> (cmp_active == $past(cpu_cmp_wdata)));

    a_r3_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> cmp_flag);

    a_r3_no_match_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> !match_pulse);

    a_r5_disconnected: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mode == 2'd0) |=> $stable(wave_out));

    a_r7_force_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_mode[1] && !tick_en) |=> $stable(wave_out));

    a_r8_blocked_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && pend_q) |=> !match_pulse);

    a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_flag_clr && !tick_en) |=> !cmp_flag);

    a_r6_flag_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !cpu_flag_clr) |=> $stable(cmp_flag));

    logic unused_ok;
    assign unused_ok = ^{count_val, cpu_force};

endmodule

bind ocu_channel ocu_channel_chk #(.W(W)) u_chk (.*);

// File: tb/ocu_channel_test.sv
module ocu_channel_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [7:0] count_val = 8'h00;
    logic       at_top = 1'b0;
    logic       at_bottom = 1'b0;
    logic [1:0] wave_mode = 2'd0;
    logic [1:0] pin_mode = 2'd0;
    logic       cpu_cmp_we = 1'b0;
    logic [7:0] cpu_cmp_wdata = 8'h00;
    logic       cpu_cnt_we = 1'b0;
    logic       cpu_force = 1'b0;
    logic       cpu_flag_clr = 1'b0;
    logic       cmp_flag, match_pulse, wave_out;
    logic [7:0] cmp_active, cmp_shadow;

    int checks = 0;
    int fails = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    ocu_channel uut (.*);

    task automatic step();
        @(posedge clk);
        #1;
        tick_en = 0; at_top = 0; at_bottom = 0;
        cpu_cmp_we = 0; cpu_cnt_we = 0; cpu_force = 0; cpu_flag_clr = 0;
    endtask

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr_cmp(input logic [7:0] v);
        cpu_cmp_we = 1; cpu_cmp_wdata = v; step();
    endtask

    task automatic tick_at(input logic [7:0] c, input logic top, input logic bot);
        tick_en = 1; count_val = c; at_top = top; at_bottom = bot; step();
    endtask

    task automatic clr_flag();
        cpu_flag_clr = 1; step();
    endtask

    task automatic t_reset();
        check("R10 flag", {7'd0, cmp_flag}, 8'h00);
        check("R10 wave_out", {7'd0, wave_out}, 8'h00);
        check("R10 pulse", {7'd0, match_pulse}, 8'h00);
        check("R10 active", cmp_active, 8'h00);
        check("R10 shadow", cmp_shadow, 8'h00);
    endtask

    task automatic t_direct();
        wave_mode = 2'd0;
        wr_cmp(8'h40);
        check("R2 active normal", cmp_active, 8'h40);
        check("R2 shadow normal", cmp_shadow, 8'h40);
    endtask

    task automatic t_toggle();
        pin_mode = 2'd1;
        tick_at(8'h40, 0, 0);
        check("R3 flag", {7'd0, cmp_flag}, 8'h01);
        check("R3 pulse", {7'd0, match_pulse}, 8'h01);
        check("R4 toggle high", {7'd0, wave_out}, 8'h01);
        tick_at(8'h41, 0, 0);
        check("R3 pulse one cycle", {7'd0, match_pulse}, 8'h00);
        check("R4 no change off match", {7'd0, wave_out}, 8'h01);
        tick_at(8'h40, 0, 0);
        check("R4 toggle low", {7'd0, wave_out}, 8'h00);
    endtask

    task automatic t_flag_clear();
        clr_flag();
        check("R9 clear", {7'd0, cmp_flag}, 8'h00);
        tick_at(8'h40, 0, 0);
        cpu_flag_clr = 1;
        tick_at(8'h40, 0, 0);
        check("R9 match wins", {7'd0, cmp_flag}, 8'h01);
        clr_flag();
    endtask

    task automatic t_set_clear_hold();
        pin_mode = 2'd3;
        tick_at(8'h40, 0, 0);
        check("R4 set", {7'd0, wave_out}, 8'h01);
        pin_mode = 2'd0;
        tick_at(8'h40, 0, 0);
        check("R5 hold high", {7'd0, wave_out}, 8'h01);
        pin_mode = 2'd2;
        tick_at(8'h40, 0, 0);
        check("R4 clear", {7'd0, wave_out}, 8'h00);
        pin_mode = 2'd0;
        cpu_force = 1; step();
        check("R5 force disconnected", {7'd0, wave_out}, 8'h00);
        clr_flag();
    endtask

    task automatic t_force();
        wave_mode = 2'd1;
        pin_mode = 2'd3;
        cpu_force = 1; step();
        check("R6 force sets", {7'd0, wave_out}, 8'h01);
        check("R6 flag untouched", {7'd0, cmp_flag}, 8'h00);
        check("R6 no pulse", {7'd0, match_pulse}, 8'h00);
        pin_mode = 2'd1;
        cpu_force = 1;
        tick_at(8'h40, 0, 0);
        check("R6 single toggle", {7'd0, wave_out}, 8'h00);
        clr_flag();
    endtask

    task automatic t_pwm_force();
        wave_mode = 2'd2;
        pin_mode = 2'd1;
        cpu_force = 1; step();
        check("R7 force ignored", {7'd0, wave_out}, 8'h00);
    endtask

    task automatic t_buffer();
        wave_mode = 2'd2;
        wr_cmp(8'h80);
        check("R1 shadow takes write", cmp_shadow, 8'h80);
        check("R1 active held", cmp_active, 8'h40);
        tick_at(8'h10, 0, 0);
        check("R1 mid count held", cmp_active, 8'h40);
        tick_at(8'hFF, 1, 0);
        check("R1 fast ignores top", cmp_active, 8'h40);
        tick_at(8'h00, 0, 1);
        check("R1 fast loads bottom", cmp_active, 8'h80);
        wave_mode = 2'd3;
        wr_cmp(8'h20);
        tick_at(8'h00, 0, 1);
        check("R1 pc ignores bottom", cmp_active, 8'h80);
        at_top = 1; step();
        check("R1 no load without tick", cmp_active, 8'h80);
        tick_at(8'hFF, 1, 0);
        check("R1 pc loads top", cmp_active, 8'h20);
        clr_flag();
    endtask

    task automatic t_block();
        wave_mode = 2'd0;
        pin_mode = 2'd1;
        wr_cmp(8'h10);
        clr_flag();
        cpu_cnt_we = 1; step();
        step(); step(); step();
        tick_at(8'h10, 0, 0);
        check("R8 blocked flag", {7'd0, cmp_flag}, 8'h00);
        check("R8 blocked pulse", {7'd0, match_pulse}, 8'h00);
        tick_at(8'h10, 0, 0);
        check("R8 unblocked", {7'd0, match_pulse}, 8'h01);
        check("R8 flag after", {7'd0, cmp_flag}, 8'h01);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_direct();
        t_toggle();
        t_flag_clear();
        t_set_clear_hold();
        t_force();
        t_pwm_force();
        t_buffer();
        t_block();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule